// File: doc/BRIEF.md
# Reset-Aligned Selectable Clock Divider

This block derives a slower system clock from a fast edge clock, dividing it by two or by four. The relationship between the divided clock and the fast clock is set only by the moment a local reset request is released. Every reset therefore produces the same phase, which lets downstream gearing logic assume a fixed alignment between the two clocks.

The reset request is asynchronous and active low. It is brought into the fast clock domain through a chain of four flip-flops. These flip-flops clear as soon as the request is asserted and release one stage per fast clock edge. The synchronized reset does two jobs. It holds the divider at rest while asserted, and it is driven out unchanged as an active-low reset for the I/O gearing registers that run on the same fast clock.

The ratio select is captured only while the synchronized reset is asserted. A new ratio therefore takes effect at the next reset release.

Top module: `edge_clk_divider`

## Requirements
- R1: `div4_sel_i` = 0 selects divide-by-2 and `div4_sel_i` = 1 selects divide-by-4. The divided clock period is 2 or 4 fast clock periods respectively.
- R2: Pulling `rst_req_n_i` low forces `clk_div_o` and `gear_rst_n_o` low at once, with no fast clock edge needed.
- R3: After `rst_req_n_i` rises, `gear_rst_n_o` stays low through the first three rising edges of `clk_fast_i`. It goes high on the fourth rising edge.
- R4: `clk_div_o` stays low until `gear_rst_n_o` is high. It rises on the first rising edge of `clk_fast_i` after that, which is the fifth edge after release.
- R5: In divide-by-2, once running, `clk_div_o` changes level on every rising edge of `clk_fast_i` (50% duty cycle).
- R6: In divide-by-4, once running, `clk_div_o` holds each level for exactly two rising edges of `clk_fast_i` (50% duty cycle).
- R7: The select is sampled on every fast clock edge while the synchronized reset is low, up to and including the edge on which `gear_rst_n_o` rises. A change made after that edge has no effect on `clk_div_o` until the next reset.
- R8: The output pattern counted from the release edge is identical after every reset. This holds whatever the divider state was when the reset arrived and whatever phase of the fast clock the reset arrived in.
- R9: `gear_rst_n_o` stays low as long as `rst_req_n_i` is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast_i | input | 1 | Fast edge clock to be divided |
| rst_req_n_i | input | 1 | Asynchronous reset request, active low |
| div4_sel_i | input | 1 | Ratio select: 0 divides by 2, 1 divides by 4 |
| clk_div_o | output | 1 | Divided clock, low while in reset |
| gear_rst_n_o | output | 1 | Synchronized reset for I/O gearing logic, active low |

## Verification
The bench uses the default four-stage chain and the 2-bit phase counter. The whole pattern from release to steady state therefore spans about twenty fast clock edges. This lets every edge be compared with a value computed from the edge count and the captured ratio. The sweep covers both initial ratios, both final ratios and a select change at several edges around the capture boundary. It also asserts the reset at three different points within the fast clock period. Together these reach every phase of both ratios and the last edge on which the select can still be captured.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  // Ratio code: the value is also the counter bit that drives the output.
  typedef enum logic {
    DIV_BY2 = 1'b0,
    DIV_BY4 = 1'b1
  } div_ratio_e;

  localparam int unsigned NUM_RATIOS = 2;
  localparam int unsigned PHASE_W    = NUM_RATIOS;

endpackage

// File: rtl/rst_sync_chain.sv
module rst_sync_chain #(
  parameter int unsigned STAGES = 4
) (
  input  logic clk_i,
  input  logic arst_req_n_i,
  output logic srst_n_o
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  // Each stage clears at once on request and fills with ones from stage 0.
  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_head
        always_comb stage_d[gi] = 1'b1;
      end else begin : g_link
        always_comb stage_d[gi] = stage_q[gi-1];
      end

      always_ff @(posedge clk_i or negedge arst_req_n_i) begin
        if (!arst_req_n_i) begin
          stage_q[gi] <= 1'b0;
        end else begin
          stage_q[gi] <= stage_d[gi];
        end
      end
    end
  endgenerate

  assign srst_n_o = stage_q[STAGES-1];

endmodule

// File: rtl/div_mode_capture.sv
module div_mode_capture
  import clkdiv_pkg::*;
(
  input  logic       clk_i,
  input  logic       arst_n_i,
  input  logic       capture_en_i,
  input  logic       sel_i,
  output div_ratio_e mode_o
);

  div_ratio_e mode_q;
  div_ratio_e mode_d;

  always_comb begin
    mode_d = mode_q;
    if (capture_en_i) begin
      mode_d = div_ratio_e'(sel_i);
    end
  end

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) begin
      mode_q <= DIV_BY2;
    end else begin
      mode_q <= mode_d;
    end
  end

  assign mode_o = mode_q;

endmodule

// File: rtl/div_phase_gen.sv
module div_phase_gen
  import clkdiv_pkg::*;
#(
  parameter int unsigned CNT_W = PHASE_W
) (
  input  logic       clk_i,
  input  logic       srst_n_i,
  input  div_ratio_e mode_i,
  output logic       clk_div_o
);

  localparam int unsigned SEL_W = (CNT_W > 1) ? $clog2(CNT_W) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             clk_q;
  logic             clk_d;
  logic [SEL_W-1:0] tap;

  // Ratio code selects the counter bit. The inverted bit makes the
  // first running edge drive the output high.
  always_comb begin
    tap   = SEL_W'(mode_i);
    cnt_d = cnt_q + CNT_W'(1);
    clk_d = ~cnt_q[tap];
  end

  always_ff @(posedge clk_i or negedge srst_n_i) begin
    if (!srst_n_i) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      clk_q <= clk_d;
    end
  end

  assign clk_div_o = clk_q;

endmodule

// File: rtl/edge_clk_divider.sv
module edge_clk_divider
  import clkdiv_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 4
) (
  input  logic clk_fast_i,
  input  logic rst_req_n_i,
  input  logic div4_sel_i,
  output logic clk_div_o,
  output logic gear_rst_n_o
);

  logic       sync_rst_n;
  div_ratio_e div_mode;
  logic       mode_is_div4;

  rst_sync_chain #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk_i        (clk_fast_i),
    .arst_req_n_i (rst_req_n_i),
    .srst_n_o     (sync_rst_n)
  );

  div_mode_capture u_mode (
    .clk_i        (clk_fast_i),
    .arst_n_i     (rst_req_n_i),
    .capture_en_i (~sync_rst_n),
    .sel_i        (div4_sel_i),
    .mode_o       (div_mode)
  );

  div_phase_gen #(
    .CNT_W(PHASE_W)
  ) u_phase (
    .clk_i     (clk_fast_i),
    .srst_n_i  (sync_rst_n),
    .mode_i    (div_mode),
    .clk_div_o (clk_div_o)
  );

  assign mode_is_div4 = (div_mode == DIV_BY4);
  assign gear_rst_n_o = sync_rst_n;

endmodule

// File: rtl/edge_clk_divider_chk.sv
module edge_clk_divider_chk #(
  parameter int unsigned STAGES = 4
) (
  input logic clk,
  input logic rst_req_n,
  input logic mode_div4,
  input logic clk_div,
  input logic gear_rst_n
);

  localparam int unsigned CW  = $clog2(STAGES + 1);
  localparam logic [CW-1:0] LIM = CW'(STAGES);

  // Counts fast clock edges since release, saturating at the chain depth.
  logic [CW-1:0] rel_cnt;
  always_ff @(posedge clk or negedge rst_req_n) begin
    if (!rst_req_n) begin
      rel_cnt <= '0;
    end else if (rel_cnt != LIM) begin
      rel_cnt <= rel_cnt + CW'(1);
    end
  end

  p_in_reset_r2: assert property (@(posedge clk)
    !rst_req_n |-> (!clk_div && !gear_rst_n));

  p_release_delay_r3: assert property (@(posedge clk) disable iff (!rst_req_n)
    gear_rst_n == (rel_cnt == LIM));

  p_first_high_r4: assert property (@(posedge clk) disable iff (!rst_req_n)
    $rose(gear_rst_n) |=> clk_div);

  p_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_req_n)
    !gear_rst_n |-> !clk_div);

  p_div2_toggle_r5: assert property (@(posedge clk) disable iff (!rst_req_n)
    (gear_rst_n && !mode_div4) |=> (clk_div != $past(clk_div)));

  p_div4_hold_r6: assert property (@(posedge clk) disable iff (!rst_req_n)
    (gear_rst_n && $past(gear_rst_n) && mode_div4 && (clk_div != $past(clk_div)))
      |=> $stable(clk_div));

  p_mode_frozen_r7: assert property (@(posedge clk) disable iff (!rst_req_n)
    gear_rst_n |=> $stable(mode_div4));

endmodule

bind edge_clk_divider edge_clk_divider_chk #(
  .STAGES(SYNC_STAGES)
) u_chk (
  .clk        (clk_fast_i),
  .rst_req_n  (rst_req_n_i),
  .mode_div4  (mode_is_div4),
  .clk_div    (clk_div_o),
  .gear_rst_n (gear_rst_n_o)
);

// File: tb/edge_clk_divider_tb.sv
`timescale 1ns/1ps
module edge_clk_divider_tb;

  localparam int CHAIN = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0;
  logic clk_div;
  logic gear_rst_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  edge_clk_divider u_dut (
    .clk_fast_i   (clk),
    .rst_req_n_i  (rst_n),
    .div4_sel_i   (sel),
    .clk_div_o    (clk_div),
    .gear_rst_n_o (gear_rst_n)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  // Assert the request off-edge, check the immediate effect, then hold.
  task automatic pulse_reset(input int off);
    @(posedge clk);
    #(off) rst_n = 1'b0;
    #1;
    check("R2 clk_div", clk_div, 1'b0);
    check("R2 gear_rst_n", gear_rst_n, 1'b0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R9 gear_rst_n", gear_rst_n, 1'b0);
      check("R2 clk_div held", clk_div, 1'b0);
    end
  endtask

  // Expected level after release edge k (k >= 5 means running).
  function automatic logic exp_clk(input int k, input logic div4);
    int m;
    if (k <= CHAIN) return 1'b0;
    m = k - CHAIN - 1;
    return div4 ? logic'(((m / 2) % 2) == 0) : logic'((m % 2) == 0);
  endfunction

  task automatic run(input logic init, input int chg_k, input logic nsel,
                     input int nedges, input int off, input bit repeat_run);
    logic  exp_mode;
    string tag;
    pulse_reset(off);
    sel = init;
    if (chg_k == 0) sel = nsel;
    exp_mode = (chg_k <= CHAIN - 1) ? nsel : init;
    rst_n = 1'b1;
    for (int k = 1; k <= nedges; k++) begin
      @(posedge clk);
      @(negedge clk);
      check("R3 gear_rst_n", gear_rst_n, logic'(k >= CHAIN));
      if (k == CHAIN + 1)                          tag = "R4 first high";
      else if (k == CHAIN + 2)                     tag = "R1 ratio";
      else if (nsel != init && k > chg_k)          tag = "R7 select frozen";
      else if (repeat_run)                         tag = "R8 repeat phase";
      else if (exp_mode)                           tag = "R6 div4";
      else                                         tag = "R5 div2";
      check(tag, clk_div, exp_clk(k, exp_mode));
      if (k == chg_k) sel = nsel;
    end
  endtask

  initial begin
    int offs[3];
    int chgs[6];
    offs[0] = 2; offs[1] = 5; offs[2] = 8;
    chgs[0] = 0; chgs[1] = 2; chgs[2] = 3; chgs[3] = 4; chgs[4] = 5; chgs[5] = 9;
    // Reset state before any release.
    #5;
    check("R2 reset clk_div", clk_div, 1'b0);
    check("R9 reset gear_rst_n", gear_rst_n, 1'b0);
    for (int o = 0; o < 3; o++) begin
      for (int a = 0; a < 2; a++) begin
        for (int b = 0; b < 2; b++) begin
          for (int c = 0; c < 6; c++) begin
            run(logic'(a), chgs[c], logic'(b), 22, offs[o], o != 0);
          end
        end
      end
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule